// File: doc/BRIEF.md
# Audio Clock Ratio Auto-Detector

This block sits in the clocking logic of an audio converter that runs with its frame clock and bit clock driven from outside. The master clock (`mclk`) clocks all of its logic. The frame clock (`lrck`) runs at the sample rate and is derived from the master clock, so it arrives synchronous to it. After reset the block measures how many master-clock cycles each frame-clock period lasts. It sorts that count into one of three supported master-to-sample-rate ratios: 256, 384 or 512.

Once two periods in a row agree, the block asserts `locked` and freezes the ratio code. It then runs a divider that gives two frame-aligned enables. The first is a sample strobe once per frame. The second is an oversampling enable that fires 64 times per nominal frame. Downstream logic uses the code and the enables in place of a fixed clock setting. The bit clock plays no part in detection, so any bit-clock rate is tolerated.

Top module: `clk_ratio_detect`

## Requirements
- R1: While `rstN` is low and just after it is released, `locked` is 0, `ratioCode` reads 3, and `sampleStrobe` and `ovsStrobe` are 0.
- R2: A period is the number of `mclk` cycles between two consecutive samples in which `lrck` is seen going from 0 to 1. The first rising edge after reset only starts a measurement. The high time of `lrck` has no effect on the measurement.
- R3: `locked` goes to 1 in the `mclk` cycle after the second of two consecutive periods that classify to the same ratio. This needs at least three rising edges after reset.
- R4: A period of 254..258 cycles classifies as code 0 (256x), 382..386 as code 1 (384x) and 510..514 as code 2 (512x). While locked, `ratioCode` carries the code. While unlocked, it reads 3.
- R5: A period outside all three windows discards any pending candidate and keeps `locked` at 0. The next valid period then counts only as a first candidate.
- R6: A valid period whose code differs from the pending candidate replaces it, so it needs one more matching period to lock.
- R7: Once set, `locked` and `ratioCode` stay unchanged until reset, whatever periods follow.
- R8: While locked, `sampleStrobe` is a one-cycle pulse in the `mclk` cycle after each `lrck` rising edge, including the edge that completes the lock.
- R9: While locked, `ovsStrobe` pulses every 4, 6 or 8 `mclk` cycles for codes 0, 1 and 2. Its phase restarts at each `lrck` rising edge, so a pulse coincides with every `sampleStrobe`, and a nominal frame holds 64 pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock; clocks all logic |
| rstN | input | 1 | Asynchronous active-low reset |
| lrck | input | 1 | Frame clock at the sample rate, synchronous to `mclk` |
| locked | output | 1 | Ratio detected and frozen |
| ratioCode | output | 2 | 0 = 256x, 1 = 384x, 2 = 512x, 3 = not yet locked |
| sampleStrobe | output | 1 | One pulse per frame, one cycle after the `lrck` rising edge |
| ovsStrobe | output | 1 | Oversampling enable, 64 per nominal frame |

## Verification
The assertions assume that `lrck` changes only between `mclk` edges and already meets its setup time to `mclk`, so a single register is enough to see its edges. They also assume that every `lrck` high and low phase lasts at least one full `mclk` cycle. The bench drives `lrck` one nanosecond after each falling `mclk` edge and builds each frame from whole `mclk` cycles, with at least one cycle high. This keeps every rising edge sampled exactly once and cleanly.

// File: rtl/acr_pkg.sv
package acr_pkg;

  localparam int RATIO_COUNT = 3;

  typedef enum logic [1:0] {
    RATIO_256  = 2'd0,
    RATIO_384  = 2'd1,
    RATIO_512  = 2'd2,
    RATIO_NONE = 2'd3
  } ratio_e;

  // datapath -> control
  typedef struct packed {
    logic edgeSeen;
    logic classValid;
    logic sameAsCand;
  } dpStatus_t;

  // control -> datapath
  typedef struct packed {
    logic loadCand;
    logic commitLock;
  } ctlStrobe_t;

endpackage

// File: rtl/acr_datapath.sv
module acr_datapath
  import acr_pkg::*;
#(
  parameter int BASE_RATIO    = 128,
  parameter int TOL           = 2,
  parameter int OVS_PER_FRAME = 64,
  localparam int MAX_NOM      = BASE_RATIO * (RATIO_COUNT + 1),
  localparam int CNT_W        = $clog2(MAX_NOM + TOL + 2),
  localparam int MAX_DIV      = MAX_NOM / OVS_PER_FRAME,
  localparam int PH_W         = $clog2(MAX_DIV + 1)
) (
  input  logic       mclk,
  input  logic       rstN,
  input  logic       lrck,
  input  logic       locked,
  input  ctlStrobe_t ctl,
  output dpStatus_t  status,
  output ratio_e     ratioCode,
  output logic       sampleStrobe,
  output logic       ovsStrobe
);

  logic             lrckQ;
  logic             rise;
  logic [CNT_W-1:0] periodCnt;
  logic [RATIO_COUNT-1:0] hit;
  ratio_e           classCode;
  ratio_e           candQ;
  ratio_e           codeQ;
  logic [PH_W-1:0]  phase;
  logic [PH_W-1:0]  divLast;
  logic             startQ;

  assign rise = lrck & ~lrckQ;

  // Period counter: reloads to 1 on a rising edge, saturates otherwise
  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      lrckQ     <= 1'b0;
      periodCnt <= '0;
      startQ    <= 1'b0;
    end else begin
      lrckQ  <= lrck;
      startQ <= rise;
      if (rise)
        periodCnt <= CNT_W'(1);
      else if (!(&periodCnt))
        periodCnt <= periodCnt + 1'b1;
    end
  end

  // One tolerance window per supported ratio
  for (genvar g = 0; g < RATIO_COUNT; g++) begin : g_win
    localparam int NOM = BASE_RATIO * (g + 2);
    assign hit[g] = (periodCnt >= CNT_W'(NOM - TOL)) &&
                    (periodCnt <= CNT_W'(NOM + TOL));
  end

  always_comb begin
    classCode = RATIO_NONE;
    for (int i = RATIO_COUNT - 1; i >= 0; i--)
      if (hit[i]) classCode = ratio_e'(2'(i));
  end

  // Candidate and frozen code registers
  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      candQ <= RATIO_NONE;
      codeQ <= RATIO_256;
    end else begin
      if (ctl.loadCand)   candQ <= classCode;
      if (ctl.commitLock) codeQ <= candQ;
    end
  end

  assign status.edgeSeen   = rise;
  assign status.classValid = (classCode != RATIO_NONE);
  assign status.sameAsCand = (classCode == candQ);

  // Oversampling divider, realigned on every frame edge
  always_comb begin
    case (codeQ)
      RATIO_384: divLast = PH_W'(BASE_RATIO * 3 / OVS_PER_FRAME - 1);
      RATIO_512: divLast = PH_W'(BASE_RATIO * 4 / OVS_PER_FRAME - 1);
      default:   divLast = PH_W'(BASE_RATIO * 2 / OVS_PER_FRAME - 1);
    endcase
  end

  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN)
      phase <= '0;
    else if (rise || (phase == divLast))
      phase <= '0;
    else
      phase <= phase + 1'b1;
  end

  assign sampleStrobe = locked & startQ;
  assign ovsStrobe    = locked & (phase == '0);
  assign ratioCode    = locked ? codeQ : RATIO_NONE;

endmodule

// File: rtl/acr_control.sv
module acr_control
  import acr_pkg::*;
(
  input  logic       mclk,
  input  logic       rstN,
  input  dpStatus_t  status,
  output ctlStrobe_t ctl,
  output logic       locked
);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_CAND   = 2'd2,
    ST_LOCKED = 2'd3
  } state_e;

  state_e state, stateNext;

  always_comb begin
    stateNext      = state;
    ctl.loadCand   = 1'b0;
    ctl.commitLock = 1'b0;
    case (state)
      ST_IDLE:
        if (status.edgeSeen) stateNext = ST_ARMED;
      ST_ARMED:
        if (status.edgeSeen && status.classValid) begin
          ctl.loadCand = 1'b1;
          stateNext    = ST_CAND;
        end
      ST_CAND:
        if (status.edgeSeen) begin
          if (status.classValid && status.sameAsCand) begin
            ctl.commitLock = 1'b1;
            stateNext      = ST_LOCKED;
          end else if (status.classValid) begin
            ctl.loadCand = 1'b1;
          end else begin
            stateNext = ST_ARMED;
          end
        end
      default: stateNext = ST_LOCKED;
    endcase
  end

  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign locked = (state == ST_LOCKED);

endmodule

// File: rtl/clk_ratio_detect.sv
module clk_ratio_detect
  import acr_pkg::*;
#(
  parameter int BASE_RATIO    = 128,
  parameter int TOL           = 2,
  parameter int OVS_PER_FRAME = 64
) (
  input  logic       mclk,
  input  logic       rstN,
  input  logic       lrck,
  output logic       locked,
  output logic [1:0] ratioCode,
  output logic       sampleStrobe,
  output logic       ovsStrobe
);

  dpStatus_t  status;
  ctlStrobe_t ctl;
  ratio_e     codeOut;

  acr_control i_ctrl (
    .mclk   (mclk),
    .rstN   (rstN),
    .status (status),
    .ctl    (ctl),
    .locked (locked)
  );

  acr_datapath #(
    .BASE_RATIO    (BASE_RATIO),
    .TOL           (TOL),
    .OVS_PER_FRAME (OVS_PER_FRAME)
  ) i_dp (
    .mclk         (mclk),
    .rstN         (rstN),
    .lrck         (lrck),
    .locked       (locked),
    .ctl          (ctl),
    .status       (status),
    .ratioCode    (codeOut),
    .sampleStrobe (sampleStrobe),
    .ovsStrobe    (ovsStrobe)
  );

  assign ratioCode = codeOut;

endmodule

// File: rtl/acr_checker.sv
module acr_checker (
  input logic       mclk,
  input logic       rstN,
  input logic       lrck,
  input logic       locked,
  input logic [1:0] ratioCode,
  input logic       sampleStrobe,
  input logic       ovsStrobe
);

  // R7
  locked_hold_chk: assert property (@(posedge mclk) disable iff (!rstN)
    locked |=> locked);

  // R7
  code_frozen_chk: assert property (@(posedge mclk) disable iff (!rstN)
    locked |=> $stable(ratioCode));

  // R4
  code_valid_chk: assert property (@(posedge mclk) disable iff (!rstN)
    locked |-> (ratioCode != 2'd3));

  // R3
  lock_on_edge_chk: assert property (@(posedge mclk) disable iff (!rstN)
    $rose(locked) |-> ($past(lrck) && !$past(lrck, 2)));

  // R8
  sample_after_rise_chk: assert property (@(posedge mclk) disable iff (!rstN)
    sampleStrobe |-> ($past(lrck) && !$past(lrck, 2)));

  // R8
  sample_single_chk: assert property (@(posedge mclk) disable iff (!rstN)
    sampleStrobe |=> !sampleStrobe);

  // R9
  ovs_aligned_chk: assert property (@(posedge mclk) disable iff (!rstN)
    sampleStrobe |-> ovsStrobe);

endmodule

bind clk_ratio_detect acr_checker i_acrChk (
  .mclk         (mclk),
  .rstN         (rstN),
  .lrck         (lrck),
  .locked       (locked),
  .ratioCode    (ratioCode),
  .sampleStrobe (sampleStrobe),
  .ovsStrobe    (ovsStrobe)
);

// File: tb/test_clk_ratio_detect.sv
module test_clk_ratio_detect;

  logic       mclk = 1'b0;
  logic       rstN = 1'b0;
  logic       lrck = 1'b0;
  logic       locked;
  logic [1:0] ratioCode;
  logic       sampleStrobe;
  logic       ovsStrobe;

  int passCnt = 0;
  int totalCnt = 0;
  int sampleCount = 0;
  int ovsCount = 0;
  bit cmpOn = 1'b0;

  // reference model state
  bit mPrev = 0;
  int mCnt = 0;
  int mStage = 0;
  int mCand = 3;
  int mCode = 0;
  int mPhase = 0;
  bit mStart = 0;
  bit mRise;
  int mV;
  int mDiv;

  always #4 mclk = ~mclk;

  clk_ratio_detect i_clk_ratio_detect (
    .mclk(mclk), .rstN(rstN), .lrck(lrck), .locked(locked),
    .ratioCode(ratioCode), .sampleStrobe(sampleStrobe), .ovsStrobe(ovsStrobe)
  );

  function automatic int classify(input int c);
    if (c >= 254 && c <= 258) return 0;
    if (c >= 382 && c <= 386) return 1;
    if (c >= 510 && c <= 514) return 2;
    return -1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    totalCnt++;
    if (act == exp) passCnt++;
    else $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
  endtask

  // behavioural reference, advanced on every rising clock
  always @(posedge mclk) begin
    if (!rstN) begin
      mPrev = 0; mCnt = 0; mStage = 0; mCand = 3;
      mCode = 0; mPhase = 0; mStart = 0;
    end else begin
      mRise = lrck && !mPrev;
      mV    = classify(mCnt);
      mDiv  = (mCode == 0) ? 4 : (mCode == 1) ? 6 : 8;
      if (mRise) begin
        if (mStage == 0) mStage = 1;
        else if (mStage == 1) begin
          if (mV >= 0) begin mCand = mV; mStage = 2; end
        end else if (mStage == 2) begin
          if (mV >= 0 && mV == mCand) begin mCode = mCand; mStage = 3; end
          else if (mV >= 0) mCand = mV;
          else mStage = 1;
        end
      end
      mPhase = mRise ? 0 : ((mPhase == mDiv - 1) ? 0 : mPhase + 1);
      mCnt   = mRise ? 1 : ((mCnt < 1023) ? mCnt + 1 : mCnt);
      mStart = mRise;
      mPrev  = lrck;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge mclk) begin
    if (cmpOn) begin
      chk("R3 locked per-cycle", int'(locked), (mStage == 3) ? 1 : 0);
      chk("R4 ratioCode per-cycle", int'(ratioCode), (mStage == 3) ? mCode : 3);
      chk("R8 sampleStrobe per-cycle", int'(sampleStrobe),
          (mStage == 3 && mStart) ? 1 : 0);
      chk("R9 ovsStrobe per-cycle", int'(ovsStrobe),
          (mStage == 3 && mPhase == 0) ? 1 : 0);
    end
    if (sampleStrobe === 1'b1) sampleCount++;
    if (ovsStrobe === 1'b1) ovsCount++;
  end

  task automatic doReset();
    @(negedge mclk); #1;
    rstN = 1'b0; lrck = 1'b0;
    repeat (3) @(negedge mclk);
    #1 rstN = 1'b1;
  endtask

  task automatic runFrame(input int p, input int highCycles);
    for (int i = 0; i < p; i++) begin
      @(negedge mclk); #1;
      lrck = (i < highCycles);
    end
  endtask

  task automatic frame(input int p);
    runFrame(p, p / 2);
  endtask

  initial begin
    #(8 * 200000);
    totalCnt++;
    $display("FAIL watchdog R3 actual=timeout expected=completion");
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge mclk);
    #1 rstN = 1'b1;
    cmpOn = 1'b1;
    repeat (2) @(negedge mclk);
    #1;
    chk("R1 locked after reset", int'(locked), 0);
    chk("R1 ratioCode after reset", int'(ratioCode), 3);
    chk("R1 sampleStrobe after reset", int'(sampleStrobe), 0);
    chk("R1 ovsStrobe after reset", int'(ovsStrobe), 0);
    repeat (8) @(negedge mclk);

    // 384x: lock needs two matching periods
    frame(384); frame(384);
    chk("R3 one period only, not locked", int'(locked), 0);
    frame(384);
    chk("R3 locked after two matches", int'(locked), 1);
    chk("R4 code for 384x", int'(ratioCode), 1);
    sampleCount = 0;
    frame(384); frame(384);
    chk("R8 one sample strobe per frame", sampleCount, 2);
    frame(300); frame(512); frame(200);
    chk("R7 lock held after odd periods", int'(locked), 1);
    chk("R7 code frozen after odd periods", int'(ratioCode), 1);

    // window edges of the 256x ratio
    doReset();
    frame(258); frame(254); frame(256);
    chk("R2 periods 258/254 measured", int'(locked), 1);
    chk("R4 code at window edges", int'(ratioCode), 0);

    // out-of-window periods
    doReset();
    frame(259); frame(259); frame(259); frame(259);
    chk("R5 period 259 rejected", int'(locked), 0);
    chk("R5 code while unlocked", int'(ratioCode), 3);
    doReset();
    frame(512); frame(300); frame(512); frame(512);
    chk("R5 candidate discarded by bad period", int'(locked), 0);
    frame(512);
    chk("R5 lock after fresh pair", int'(locked), 1);
    chk("R5 code after fresh pair", int'(ratioCode), 2);

    // candidate replacement
    doReset();
    frame(256); frame(384); frame(384);
    chk("R6 no lock on differing pair", int'(locked), 0);
    frame(512);
    chk("R6 lock on replaced candidate", int'(locked), 1);
    chk("R6 code of replaced candidate", int'(ratioCode), 1);

    // 512x with a one-cycle-high frame clock
    doReset();
    runFrame(512, 1); runFrame(512, 1); runFrame(512, 1);
    chk("R2 narrow high pulse locks", int'(locked), 1);
    chk("R4 code for 512x", int'(ratioCode), 2);
    ovsCount = 0;
    runFrame(512, 1);
    chk("R9 64 oversample pulses per frame", ovsCount, 64);
    doReset();
    frame(256); frame(256); frame(256);
    ovsCount = 0;
    frame(256);
    chk("R9 64 pulses at 256x", ovsCount, 64);

    repeat (4) @(negedge mclk);
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

endmodule